// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Mode Decode and Identifier Readout

This block is a synthesizable model of a byte-wide one-time-programmable memory with a parameterized depth. Three control inputs select its mode: an active-low chip select, a two-bit code for the combined output-enable / programming-supply pin, and a flag that marks high voltage on the identifier address line. The decoded modes are read, output disable, standby, program, program inhibit and identifier readout. Analog levels appear only as these encoded flags.

Every cell starts erased at 0xFF. A program pulse can only clear bits, so the stored byte becomes the bitwise AND of the old contents and the applied data. The array is built from a synchronous-read memory. A program pulse therefore performs a read-modify-write over two cycles. A synchronous reset erases the whole array, which stands in for erasure by light.

The output side has a data byte and a separate drive-enable flag that an enclosing tristate pad uses. Both are registered. A change on the inputs appears at the outputs after the second rising clock edge.

Top module: `otp_byte_store`

## Requirements
- R1: While reset is held and right after it, `rd_en` is 0 and `rd_data` is 0x00. After reset every location reads 0xFF.
- R2: With `cs_n`=0, `oe_code`=2'b00 (low) and `id_hv`=0, the block drives the byte stored at `addr`. It sets `rd_en`=1 with that byte on `rd_data` after the second rising edge of the held inputs.
- R3: With `cs_n`=1 the block is in standby and `rd_en` is 0, whatever the value of `oe_code` or `id_hv`.
- R4: With `cs_n`=0 and `oe_code`=2'b01 (high), outputs are disabled (`rd_en`=0).
- R5: With `cs_n`=0, `oe_code`=2'b00 and `id_hv`=1, `rd_data` is 0x20 when `addr[0]`=0 and 0x42 when `addr[0]`=1. All other address bits are ignored, and `rd_en`=1.
- R6: With `oe_code`=2'b10 (programming level), a falling edge of `cs_n` (low in a cycle after a cycle with it high) is a program pulse. The pulse stores the old byte AND `wr_data` at `addr`.
- R7: With `oe_code`=2'b10 and `cs_n`=1, nothing is written and `rd_en` is 0.
- R8: Programming never turns a 0 bit into a 1. Programming 0xFF leaves a byte unchanged.
- R9: Code `oe_code`=2'b11 is reserved and behaves as high: with `cs_n`=0 the outputs are disabled and nothing is written.
- R10: A reset asserted after programming returns every programmed location to 0xFF.
- R11: The write of a program pulse lands one cycle after the pulse. A read of another address issued in that cycle returns that address's own contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also erases the array |
| cs_n | input | 1 | Active-low chip select |
| oe_code | input | 2 | Output-enable / supply code: 00 low, 01 high, 10 programming level, 11 reserved (as high) |
| id_hv | input | 1 | High-voltage flag on the identifier address line |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Byte applied during a program pulse |
| rd_data | output | 8 | Registered output byte, 0x00 when not driven |
| rd_en | output | 1 | Registered drive enable for the data pads |

## Verification
A program pulse's write into the array and a fresh read of another location can fall in the same cycle. This happens because the read-modify-write occupies the memory one edge after the pulse. The bench provokes this by driving a read of a different address in the cycle right after the pulse. It judges the result by requiring that the read returns the unrelated byte from its reference model, and that a later read of the programmed address shows the ANDed value. Sweeps over every address of the default 256-byte configuration check erase, two programming passes, and identifier readout with varied upper address bits.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] ID_MAKER    = 8'h20;
  localparam logic [BYTE_W-1:0] ID_PART     = 8'h42;

  localparam logic [1:0] OE_LOW  = 2'b00;
  localparam logic [1:0] OE_HIGH = 2'b01;
  localparam logic [1:0] OE_PROG = 2'b10;
  localparam logic [1:0] OE_RSVD = 2'b11;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_READ    = 3'd1,
    MODE_ODIS    = 3'd2,
    MODE_PROG    = 3'd3,
    MODE_INHIBIT = 3'd4,
    MODE_IDENT   = 3'd5
  } mode_e;

  function automatic mode_e decode_mode(input logic cs_n, input logic [1:0] oe,
                                        input logic hv);
    mode_e m;
    if (cs_n) begin
      m = (oe == OE_PROG) ? MODE_INHIBIT : MODE_STANDBY;
    end else begin
      unique case (oe)
        OE_LOW:  m = hv ? MODE_IDENT : MODE_READ;
        OE_PROG: m = MODE_PROG;
        default: m = MODE_ODIS;
      endcase
    end
    return m;
  endfunction

  function automatic logic mode_drives(input mode_e m);
    return (m == MODE_READ) || (m == MODE_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic       cs_n,
  input  logic [1:0] oe_code,
  input  logic       id_hv,
  output mode_e      mode
);

  always_comb begin
    mode = decode_mode(cs_n, oe_code, id_hv);
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_byte
);

  logic [BYTE_W-1:0] cells [DEPTH];

  // Write port; reset sweeps every cell back to the erased value.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= ERASED_BYTE;
      end
    end else if (wr_en) begin
      cells[wr_addr] <= wr_byte;
    end
  end

  // Synchronous read port, read-before-write on an address collision.
  always_ff @(posedge clk) begin
    rd_q <= cells[rd_addr];
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] old_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_byte
);

  logic              cs_n_prev;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [BYTE_W-1:0] pend_data;
  logic              pulse;

  // A pulse is the first low cycle of chip select at programming level.
  assign pulse = (mode == MODE_PROG) && cs_n_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_prev <= 1'b1;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= ERASED_BYTE;
    end else begin
      cs_n_prev <= cs_n;
      pend_v    <= pulse;
      if (pulse) begin
        pend_addr <= addr;
        pend_data <= wr_data;
      end
    end
  end

  // Old contents arrive from the array one edge after the pulse.
  assign wr_en   = pend_v;
  assign wr_addr = pend_addr;
  assign wr_byte = old_byte & pend_data;

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_q,
  input  logic              a0_q,
  input  logic [BYTE_W-1:0] array_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_en
);

  logic [BYTE_W-1:0] pick;
  logic              drive;

  always_comb begin
    drive = mode_drives(mode_q);
    if (mode_q == MODE_IDENT) begin
      pick = a0_q ? ID_PART : ID_MAKER;
    end else begin
      pick = array_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_en   <= 1'b0;
    end else begin
      rd_data <= drive ? pick : '0;
      rd_en   <= drive;
    end
  end

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [1:0]        oe_code,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              rd_en
);

  mode_e             mode;
  mode_e             mode_q;
  logic              a0_q;
  logic [BYTE_W-1:0] array_q;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_byte;

  otp_mode_decode u_decode (
    .cs_n    (cs_n),
    .oe_code (oe_code),
    .id_hv   (id_hv),
    .mode    (mode)
  );

  otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (addr),
    .rd_q    (array_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_byte (wr_byte)
  );

  otp_prog_ctrl #(.ADDR_W(ADDR_W)) u_prog (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .mode     (mode),
    .addr     (addr),
    .wr_data  (wr_data),
    .old_byte (array_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_byte  (wr_byte)
  );

  // Mode and identifier select travel alongside the array read.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STANDBY;
      a0_q   <= 1'b0;
    end else begin
      mode_q <= mode;
      a0_q   <= addr[0];
    end
  end

  otp_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .mode_q  (mode_q),
    .a0_q    (a0_q),
    .array_q (array_q),
    .rd_data (rd_data),
    .rd_en   (rd_en)
  );

endmodule

// File: rtl/otp_byte_store_chk.sv
module otp_byte_store_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic [1:0]        oe_code,
  input logic              id_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data,
  input logic              rd_en
);

  logic [1:0] since_rst;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  assign armed = (since_rst == 2'd2);

  // R1: outputs idle in the cycle after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!rd_en && rd_data == 8'h00));

  // R3: chip select high keeps the pads undriven
  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cs_n, 2)) |-> !rd_en);

  // R4 / R9: output enable high or reserved disables the pads
  assert_outdis_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(cs_n, 2) && $past(oe_code, 2) != 2'b00) |-> !rd_en);

  // R2: read conditions drive the pads
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(cs_n, 2) && $past(oe_code, 2) == 2'b00) |-> rd_en);

  // R5: identifier readout returns the fixed bytes
  assert_ident_bytes_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(cs_n, 2) && $past(oe_code, 2) == 2'b00 && $past(id_hv, 2))
      |-> (rd_data == ($past(addr[0], 2) ? 8'h42 : 8'h20)));

  // R3: an undriven pad carries zero data
  assert_quiet_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == 8'h00));

endmodule

bind otp_byte_store otp_byte_store_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .oe_code (oe_code),
  .id_hv   (id_hv),
  .addr    (addr),
  .rd_data (rd_data),
  .rd_en   (rd_en)
);

// File: tb/test_otp_byte_store.sv
module test_otp_byte_store;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic [1:0]    oe_code = 2'b01;
  logic          id_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic [7:0]    rd_data;
  logic          rd_en;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  otp_byte_store #(.ADDR_W(AW)) i_otp_byte_store (
    .clk (clk), .rst (rst), .cs_n (cs_n), .oe_code (oe_code), .id_hv (id_hv),
    .addr (addr), .wr_data (wr_data), .rd_data (rd_data), .rd_en (rd_en)
  );

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got en/data=%h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic c, input logic [1:0] oe, input logic hv,
                       input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; oe_code = oe; id_hv = hv; addr = a; wr_data = d;
  endtask

  task automatic observe(input logic c, input logic [1:0] oe, input logic hv,
                         input logic [AW-1:0] a, input string req,
                         input logic [8:0] exp);
    apply(c, oe, hv, a, 8'h00);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(req, {rd_en, rd_data}, exp);
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
    apply(1'b1, 2'b10, 1'b0, a, d);
    apply(1'b0, 2'b10, 1'b0, a, d);
    apply(1'b1, 2'b10, 1'b0, a, d);
    apply(1'b1, 2'b01, 1'b0, a, d);
    model[a] = model[a] & d;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      observe(1'b0, 2'b00, 1'b0, AW'(a), req, {1'b1, model[a]});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b1; oe_code = 2'b01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 reset idle", {rd_en, rd_data}, 9'h000);
    rst = 1'b0;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    do_reset();
    sweep("R1 erased read");

    // R2 / R6: first programming pass
    for (int a = 0; a < DEPTH; a++) program_byte(AW'(a), 8'(a ^ 8'h5A));
    sweep("R2 R6 first pass");

    // R8: second pass only clears further bits; 0xFF leaves bytes alone
    for (int a = 0; a < DEPTH; a++) begin
      if (a % 3 == 0) program_byte(AW'(a), 8'hFF);
      else program_byte(AW'(a), {a[3:0], a[7:4]} ^ 8'hF0);
    end
    sweep("R8 second pass");

    // R3: standby under every code and identifier flag
    for (int oe = 0; oe < 4; oe++) begin
      observe(1'b1, 2'(oe), 1'b0, 8'h11, "R3 standby", 9'h000);
      observe(1'b1, 2'(oe), 1'b1, 8'h10, "R3 standby hv", 9'h000);
    end

    // R4 / R9: output disable, plain and reserved code
    observe(1'b0, 2'b01, 1'b0, 8'h22, "R4 output disable", 9'h000);
    observe(1'b0, 2'b11, 1'b0, 8'h22, "R9 reserved as high", 9'h000);

    // R9: reserved code with select falling writes nothing
    apply(1'b1, 2'b11, 1'b0, 8'h30, 8'h00);
    apply(1'b0, 2'b11, 1'b0, 8'h30, 8'h00);
    apply(1'b1, 2'b11, 1'b0, 8'h30, 8'h00);
    observe(1'b0, 2'b00, 1'b0, 8'h30, "R9 no write", {1'b1, model[8'h30]});

    // R5: identifier bytes across all addresses
    for (int a = 0; a < DEPTH; a++) begin
      observe(1'b0, 2'b00, 1'b1, AW'(a), "R5 identifier",
              {1'b1, (a % 2 == 1) ? 8'h42 : 8'h20});
    end

    // R7: inhibit held several cycles, no drive, no write
    apply(1'b1, 2'b10, 1'b0, 8'h44, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 inhibit quiet", {rd_en, rd_data}, 9'h000);
    observe(1'b0, 2'b00, 1'b0, 8'h44, "R7 unchanged", {1'b1, model[8'h44]});

    // R11: read of another address in the write cycle
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] pa;
      logic [AW-1:0] ra;
      pa = AW'(k * 17 + 3);
      ra = AW'(k * 17 + 9);
      apply(1'b1, 2'b10, 1'b0, pa, 8'h0F);
      apply(1'b0, 2'b10, 1'b0, pa, 8'h0F);
      model[pa] = model[pa] & 8'h0F;
      apply(1'b0, 2'b00, 1'b0, ra, 8'h00);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      check("R11 read beside write", {rd_en, rd_data}, {1'b1, model[ra]});
      observe(1'b0, 2'b00, 1'b0, pa, "R11 write landed", {1'b1, model[pa]});
    end

    // R10: reset erases programmed bytes
    do_reset();
    sweep("R10 erased again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule